// File: doc/BRIEF.md
# Secure return stack buffer

This block predicts the target of return instructions for one hardware thread. Every call pushes its return address, together with the privilege mode of the code that executed the call, onto a fixed-depth last-in-first-out store. Every return pops the most recent entry and presents it as the prediction in the same cycle as the return request. When the store is full, a further call overwrites the oldest entry, so a long run of calls keeps only the newest `DEPTH` addresses.

Several hardening options sit around the stack. A return on an empty stack is reported as underflow. It can optionally borrow the indirect-branch predictor's target, and a restriction can require that target to have been trained in the current privilege mode. A guard mode stops host code from using entries created by a guest. Three events can wipe the stack: a prediction-barrier command, an exit from a virtual machine and a translation-cache flush. Each one is enabled by its own option.

A build option models an imperfect barrier. After a barrier wipe, the address of the last call made before the barrier can still be predicted for a return on the empty stack. That address stays available until the first call made after the barrier.

Top module: `secure_rsb`

## Requirements
- R1: A call pushes `call_addr_i` and a return predicts the most recently pushed entry that has not been popped. `pred_valid_o` and `pred_target_o` are valid in the same cycle as `ret_i`.
- R2: A call on a full stack overwrites the oldest entry and the occupancy stays at `DEPTH`. After `DEPTH+k` calls, `DEPTH` returns predict the newest `DEPTH` addresses, newest first, and the next return underflows.
- R3: A return on an empty stack raises `underflow_o`. With no fallback source, it has `pred_valid_o` low. `underflow_o` is low whenever `ret_i` is low or the stack holds an entry.
- R4: With `cfg_alt_en_i` set, a return on an empty stack with `alt_valid_i` high predicts `alt_target_i` and raises `fallback_o`. With `cfg_alt_en_i` clear, the same return gives no prediction.
- R5: With `cfg_alt_restrict_i` set, the fallback target is used only when `alt_mode_i` equals `mode_i`. Otherwise `pred_valid_o` and `fallback_o` stay low.
- R6: Mode encoding: bit 1 set means guest and bit 0 set means supervisor. With `cfg_guard_i` set and `mode_i[1]` clear, a return whose top entry was pushed with bit 1 set gives no prediction. The entry is still popped.
- R7: `barrier_i` empties the stack when `cfg_barrier_clr_i` is set and has no effect when it is clear.
- R8: `vmexit_i` empties the stack when `cfg_guard_i` is set and has no effect when it is clear.
- R9: `tlb_flush_i` empties the stack when `cfg_tlb_clr_i` is set and has no effect when it is clear.
- R10: With `LEAK_LAST_CALL` set, a barrier wipe leaves the last call address before the barrier predictable for returns on the empty stack. A call in the barrier cycle counts as before the barrier. This prediction takes priority over the fallback target, keeps `underflow_o` high and ends at the first call after the barrier.
- R11: When a call and a return occur in the same cycle, the return predicts and removes the old top and the call then pushes. Occupancy is unchanged.
- R12: A wipe in the same cycle as a call or return takes effect after them, so the stack is empty on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| call_i | input | 1 | Call executed this cycle |
| call_addr_i | input | ADDR_W | Return address pushed by the call |
| ret_i | input | 1 | Return needing a prediction this cycle |
| mode_i | input | 2 | Current mode: bit 1 guest, bit 0 supervisor |
| alt_valid_i | input | 1 | Indirect predictor offers a target |
| alt_target_i | input | ADDR_W | Indirect predictor target |
| alt_mode_i | input | 2 | Mode in which the indirect target was trained |
| cfg_alt_en_i | input | 1 | Allow fallback to the indirect predictor on empty stack |
| cfg_alt_restrict_i | input | 1 | Fallback only for a same-mode target |
| cfg_guard_i | input | 1 | Host ignores guest entries; VM exit wipes |
| cfg_barrier_clr_i | input | 1 | Barrier command wipes the stack |
| cfg_tlb_clr_i | input | 1 | Translation flush wipes the stack |
| barrier_i | input | 1 | Prediction-barrier command |
| vmexit_i | input | 1 | Virtual-machine exit event |
| tlb_flush_i | input | 1 | Translation-cache flush event |
| pred_valid_o | output | 1 | Prediction present |
| pred_target_o | output | ADDR_W | Predicted return target (zero when not valid) |
| underflow_o | output | 1 | Return arrived on an empty stack |
| fallback_o | output | 1 | Prediction came from the indirect predictor |

## Verification
A corrupted write pointer or occupancy count shows on the very next return. That return either predicts the wrong address or raises underflow with entries still present. A stale count near the full boundary shows only after `DEPTH` returns, so overflow runs pop the whole stack and one more. A missing wipe or a leak that ends early shows on the first return after the event. Every return is compared against the expected target and flags in the cycle it is issued.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
   localparam int MODE_W    = 2;
   localparam int GUEST_BIT = 1;
   localparam int SUP_BIT   = 0;

   function automatic logic is_guest(input logic [MODE_W-1:0] m);
      return m[GUEST_BIT];
   endfunction
endpackage

// File: rtl/rsb_store.sv
module rsb_store
   import rsb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [ADDR_W-1:0] push_addr_i,
   input  logic [MODE_W-1:0] push_mode_i,
   input  logic              pop_i,
   input  logic              wipe_i,
   output logic [ADDR_W-1:0] top_addr_o,
   output logic [MODE_W-1:0] top_mode_o,
   output logic              empty_o,
   output logic [CNT_W-1:0]  occ_o
);
   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic [MODE_W-1:0] mode;
   } slot_t;

   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   slot_t             slots [DEPTH];
   logic [PTR_W-1:0]  wr_ptr;
   logic [PTR_W-1:0]  top_ptr;
   logic [CNT_W-1:0]  occ;
   logic              do_pop;
   logic [PTR_W-1:0]  wr_sel;

   assign top_ptr = wr_ptr - 1'b1;
   assign do_pop  = pop_i && (occ != '0);
   assign wr_sel  = do_pop ? top_ptr : wr_ptr;

   always_ff @(posedge clk) begin
      if (push_i) begin
         slots[wr_sel].addr <= push_addr_i;
         slots[wr_sel].mode <= push_mode_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         occ    <= '0;
      end else begin
         unique case ({do_pop, push_i})
            2'b10: begin
               wr_ptr <= top_ptr;
               occ    <= occ - 1'b1;
            end
            2'b01: begin
               wr_ptr <= wr_ptr + 1'b1;
               occ    <= (occ == FULL) ? FULL : occ + 1'b1;
            end
            default: ;
         endcase
         if (wipe_i) occ <= '0;
      end
   end

   assign top_addr_o = slots[top_ptr].addr;
   assign top_mode_o = slots[top_ptr].mode;
   assign empty_o    = (occ == '0);
   assign occ_o      = occ;
endmodule

// File: rtl/rsb_leak.sv
module rsb_leak #(
   parameter int ADDR_W = 32,
   parameter bit ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [ADDR_W-1:0] push_addr_i,
   input  logic              barrier_wipe_i,
   output logic              leak_valid_o,
   output logic [ADDR_W-1:0] leak_addr_o
);
   generate
      if (ENABLE) begin : g_leak
         logic              last_seen;
         logic [ADDR_W-1:0] last_addr;
         logic              leak_v;
         logic [ADDR_W-1:0] leak_a;
         logic              seen_nxt;
         logic [ADDR_W-1:0] addr_nxt;

         assign seen_nxt = last_seen | push_i;
         assign addr_nxt = push_i ? push_addr_i : last_addr;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               last_seen <= 1'b0;
               last_addr <= '0;
               leak_v    <= 1'b0;
               leak_a    <= '0;
            end else begin
               last_seen <= seen_nxt;
               last_addr <= addr_nxt;
               if (barrier_wipe_i) begin
                  leak_v <= seen_nxt;
                  leak_a <= addr_nxt;
               end else if (push_i) begin
                  leak_v <= 1'b0;
               end
            end
         end
         assign leak_valid_o = leak_v;
         assign leak_addr_o  = leak_a;
      end else begin : g_noleak
         assign leak_valid_o = 1'b0;
         assign leak_addr_o  = '0;
      end
   endgenerate
endmodule

// File: rtl/rsb_select.sv
module rsb_select
   import rsb_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              ret_i,
   input  logic              empty_i,
   input  logic [ADDR_W-1:0] top_addr_i,
   input  logic [MODE_W-1:0] top_mode_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              guard_i,
   input  logic              leak_valid_i,
   input  logic [ADDR_W-1:0] leak_addr_i,
   input  logic              alt_en_i,
   input  logic              alt_restrict_i,
   input  logic              alt_valid_i,
   input  logic [ADDR_W-1:0] alt_target_i,
   input  logic [MODE_W-1:0] alt_mode_i,
   output logic              pred_valid_o,
   output logic [ADDR_W-1:0] pred_target_o,
   output logic              underflow_o,
   output logic              fallback_o
);
   logic blocked_top;
   logic alt_ok;

   assign blocked_top = guard_i && !is_guest(mode_i) && is_guest(top_mode_i);
   assign alt_ok      = alt_en_i && alt_valid_i &&
                        (!alt_restrict_i || (alt_mode_i == mode_i));

   always_comb begin
      pred_valid_o  = 1'b0;
      pred_target_o = '0;
      underflow_o   = 1'b0;
      fallback_o    = 1'b0;
      if (ret_i) begin
         if (!empty_i) begin
            if (!blocked_top) begin
               pred_valid_o  = 1'b1;
               pred_target_o = top_addr_i;
            end
         end else begin
            underflow_o = 1'b1;
            if (leak_valid_i) begin
               pred_valid_o  = 1'b1;
               pred_target_o = leak_addr_i;
            end else if (alt_ok) begin
               pred_valid_o  = 1'b1;
               pred_target_o = alt_target_i;
               fallback_o    = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/secure_rsb.sv
module secure_rsb
   import rsb_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter int DEPTH          = 16,
   parameter bit LEAK_LAST_CALL = 1'b1,
   localparam int CNT_W         = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              call_i,
   input  logic [ADDR_W-1:0] call_addr_i,
   input  logic              ret_i,
   input  logic [1:0]        mode_i,
   input  logic              alt_valid_i,
   input  logic [ADDR_W-1:0] alt_target_i,
   input  logic [1:0]        alt_mode_i,
   input  logic              cfg_alt_en_i,
   input  logic              cfg_alt_restrict_i,
   input  logic              cfg_guard_i,
   input  logic              cfg_barrier_clr_i,
   input  logic              cfg_tlb_clr_i,
   input  logic              barrier_i,
   input  logic              vmexit_i,
   input  logic              tlb_flush_i,
   output logic              pred_valid_o,
   output logic [ADDR_W-1:0] pred_target_o,
   output logic              underflow_o,
   output logic              fallback_o
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("secure_rsb: DEPTH must be a power of two of at least 2");
      end
      if (ADDR_W < 2) begin : g_bad_width
         $error("secure_rsb: ADDR_W must be at least 2");
      end
   endgenerate

   logic              barrier_wipe;
   logic              any_wipe;
   logic [ADDR_W-1:0] top_addr;
   logic [MODE_W-1:0] top_mode;
   logic              empty;
   logic [CNT_W-1:0]  occ;
   logic              leak_valid;
   logic [ADDR_W-1:0] leak_addr;

   assign barrier_wipe = barrier_i && cfg_barrier_clr_i;
   assign any_wipe     = barrier_wipe ||
                         (vmexit_i && cfg_guard_i) ||
                         (tlb_flush_i && cfg_tlb_clr_i);

   rsb_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (call_i),
      .push_addr_i (call_addr_i),
      .push_mode_i (mode_i),
      .pop_i       (ret_i),
      .wipe_i      (any_wipe),
      .top_addr_o  (top_addr),
      .top_mode_o  (top_mode),
      .empty_o     (empty),
      .occ_o       (occ)
   );

   rsb_leak #(.ADDR_W(ADDR_W), .ENABLE(LEAK_LAST_CALL)) u_leak (
      .clk            (clk),
      .rst_n          (rst_n),
      .push_i         (call_i),
      .push_addr_i    (call_addr_i),
      .barrier_wipe_i (barrier_wipe),
      .leak_valid_o   (leak_valid),
      .leak_addr_o    (leak_addr)
   );

   rsb_select #(.ADDR_W(ADDR_W)) u_select (
      .ret_i          (ret_i),
      .empty_i        (empty),
      .top_addr_i     (top_addr),
      .top_mode_i     (top_mode),
      .mode_i         (mode_i),
      .guard_i        (cfg_guard_i),
      .leak_valid_i   (leak_valid),
      .leak_addr_i    (leak_addr),
      .alt_en_i       (cfg_alt_en_i),
      .alt_restrict_i (cfg_alt_restrict_i),
      .alt_valid_i    (alt_valid_i),
      .alt_target_i   (alt_target_i),
      .alt_mode_i     (alt_mode_i),
      .pred_valid_o   (pred_valid_o),
      .pred_target_o  (pred_target_o),
      .underflow_o    (underflow_o),
      .fallback_o     (fallback_o)
   );
endmodule

// File: rtl/rsb_checker.sv
module rsb_checker #(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 16,
   parameter int CNT_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              call_i,
   input logic              ret_i,
   input logic [1:0]        mode_i,
   input logic [1:0]        alt_mode_i,
   input logic [ADDR_W-1:0] alt_target_i,
   input logic              cfg_alt_restrict_i,
   input logic              cfg_guard_i,
   input logic              cfg_barrier_clr_i,
   input logic              cfg_tlb_clr_i,
   input logic              barrier_i,
   input logic              vmexit_i,
   input logic              tlb_flush_i,
   input logic              pred_valid_o,
   input logic [ADDR_W-1:0] pred_target_o,
   input logic              underflow_o,
   input logic              fallback_o,
   input logic [CNT_W-1:0]  occ
);
   logic wipe;
   assign wipe = (barrier_i && cfg_barrier_clr_i) || (vmexit_i && cfg_guard_i) ||
                 (tlb_flush_i && cfg_tlb_clr_i);

   a_r1_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && !ret_i && !wipe && occ < CNT_W'(DEPTH)) |=> occ == $past(occ) + 1'b1);
   a_r2_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CNT_W'(DEPTH));
   a_r3_underflow_needs_ret: assert property (@(posedge clk) disable iff (!rst_n)
      underflow_o |-> ret_i);
   a_r3_no_underflow_when_filled: assert property (@(posedge clk) disable iff (!rst_n)
      (occ != '0) |-> !underflow_o);
   a_r4_fallback_target: assert property (@(posedge clk) disable iff (!rst_n)
      fallback_o |-> (pred_valid_o && underflow_o && pred_target_o == alt_target_i));
   a_r5_restrict_same_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (fallback_o && cfg_alt_restrict_i) |-> alt_mode_i == mode_i);
   a_r7_barrier_wipe: assert property (@(posedge clk) disable iff (!rst_n)
      (barrier_i && cfg_barrier_clr_i) |=> occ == '0);
   a_r8_vmexit_wipe: assert property (@(posedge clk) disable iff (!rst_n)
      (vmexit_i && cfg_guard_i) |=> occ == '0);
   a_r9_tlb_wipe: assert property (@(posedge clk) disable iff (!rst_n)
      (tlb_flush_i && cfg_tlb_clr_i) |=> occ == '0);
   a_r11_pop_push_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && ret_i && occ != '0 && !wipe) |=> occ == $past(occ));
endmodule

bind secure_rsb rsb_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk                (clk),
   .rst_n              (rst_n),
   .call_i             (call_i),
   .ret_i              (ret_i),
   .mode_i             (mode_i),
   .alt_mode_i         (alt_mode_i),
   .alt_target_i       (alt_target_i),
   .cfg_alt_restrict_i (cfg_alt_restrict_i),
   .cfg_guard_i        (cfg_guard_i),
   .cfg_barrier_clr_i  (cfg_barrier_clr_i),
   .cfg_tlb_clr_i      (cfg_tlb_clr_i),
   .barrier_i          (barrier_i),
   .vmexit_i           (vmexit_i),
   .tlb_flush_i        (tlb_flush_i),
   .pred_valid_o       (pred_valid_o),
   .pred_target_o      (pred_target_o),
   .underflow_o        (underflow_o),
   .fallback_o         (fallback_o),
   .occ                (occ)
);

// File: tb/secure_rsb_bench.sv
`timescale 1ns/1ps
module secure_rsb_bench;
   localparam int AW = 32;
   localparam int DP = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic call_i = 0, ret_i = 0, alt_valid_i = 0;
   logic [AW-1:0] call_addr_i = '0, alt_target_i = '0;
   logic [1:0] mode_i = 2'b01, alt_mode_i = 2'b01;
   logic cfg_alt_en_i = 0, cfg_alt_restrict_i = 0, cfg_guard_i = 0;
   logic cfg_barrier_clr_i = 0, cfg_tlb_clr_i = 0;
   logic barrier_i = 0, vmexit_i = 0, tlb_flush_i = 0;
   logic pred_valid_o, underflow_o, fallback_o;
   logic [AW-1:0] pred_target_o;

   int n_chk = 0, n_bad = 0;
   string cur_req = "R3";
   bit finished = 0;

   always #2 clk = ~clk;

   secure_rsb #(.ADDR_W(AW), .DEPTH(DP), .LEAK_LAST_CALL(1'b1)) u_secure_rsb (.*);

   // behavioural reference
   logic [AW-1:0] mq_a[$];
   logic [1:0]    mq_m[$];
   bit            m_last_v, m_leak_v;
   logic [AW-1:0] m_last_a, m_leak_a;

   always @(posedge clk) begin
      if (!rst_n) begin
         mq_a.delete(); mq_m.delete();
         m_last_v = 0; m_leak_v = 0; m_last_a = '0; m_leak_a = '0;
      end else begin
         if (ret_i && mq_a.size() > 0) begin
            void'(mq_a.pop_back()); void'(mq_m.pop_back());
         end
         if (call_i) begin
            mq_a.push_back(call_addr_i); mq_m.push_back(mode_i);
            if (mq_a.size() > DP) begin
               void'(mq_a.pop_front()); void'(mq_m.pop_front());
            end
            m_last_v = 1; m_last_a = call_addr_i; m_leak_v = 0;
         end
         if (barrier_i && cfg_barrier_clr_i) begin
            mq_a.delete(); mq_m.delete();
            m_leak_v = m_last_v; m_leak_a = m_last_a;
         end
         if ((vmexit_i && cfg_guard_i) || (tlb_flush_i && cfg_tlb_clr_i)) begin
            mq_a.delete(); mq_m.delete();
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic ev, eu, ef;
         logic [AW-1:0] et;
         ev = 0; eu = 0; ef = 0; et = '0;
         if (ret_i) begin
            if (mq_a.size() > 0) begin
               if (!(cfg_guard_i && !mode_i[1] && mq_m[$][1])) begin
                  ev = 1; et = mq_a[$];
               end
            end else begin
               eu = 1;
               if (m_leak_v) begin
                  ev = 1; et = m_leak_a;
               end else if (cfg_alt_en_i && alt_valid_i &&
                            (!cfg_alt_restrict_i || alt_mode_i == mode_i)) begin
                  ev = 1; ef = 1; et = alt_target_i;
               end
            end
         end
         n_chk++;
         if (pred_valid_o !== ev || underflow_o !== eu || fallback_o !== ef ||
             (ev && pred_target_o !== et)) begin
            n_bad++;
            $display("FAIL %s: got v=%0b u=%0b f=%0b t=%h exp v=%0b u=%0b f=%0b t=%h",
                     cur_req, pred_valid_o, underflow_o, fallback_o, pred_target_o,
                     ev, eu, ef, et);
         end
      end
   end

   task automatic step(input logic c, input logic [AW-1:0] a, input logic r);
      call_i = c; call_addr_i = a; ret_i = r;
      @(posedge clk); #1;
      call_i = 0; ret_i = 0; barrier_i = 0; vmexit_i = 0; tlb_flush_i = 0;
   endtask

   task automatic fill(input int n, input logic [AW-1:0] base);
      for (int i = 0; i < n; i++) step(1, base + AW'(i), 0);
   endtask

   task automatic drain(input int n);
      for (int i = 0; i < n; i++) step(0, '0, 1);
   endtask

   initial begin
      #(4 * 100000);
      if (!finished) begin
         finished = 1;
         n_bad++;
         $display("FAIL watchdog: got hang exp completion");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      cur_req = "R3"; drain(2);                       // empty after reset
      cur_req = "R1"; fill(3, 32'h100); drain(4);
      cur_req = "R11"; fill(2, 32'h200);
      step(1, 32'h2C0, 1); drain(3);
      cur_req = "R2"; fill(DP + 2, 32'h300); drain(DP + 1);
      cur_req = "R4"; alt_valid_i = 1; alt_target_i = 32'hA000; drain(1);
      cfg_alt_en_i = 1; drain(1); alt_valid_i = 0; drain(1); alt_valid_i = 1;
      cur_req = "R5"; cfg_alt_restrict_i = 1; alt_mode_i = 2'b11; drain(1);
      alt_mode_i = mode_i; drain(1);
      cfg_alt_restrict_i = 0; cfg_alt_en_i = 0; alt_valid_i = 0;
      cur_req = "R6"; cfg_guard_i = 1; mode_i = 2'b10; step(1, 32'h600, 0);
      mode_i = 2'b01; drain(2);
      mode_i = 2'b11; step(1, 32'h610, 0); mode_i = 2'b01; cfg_guard_i = 0; drain(2);
      cur_req = "R7"; fill(2, 32'h700); barrier_i = 1; step(0, '0, 0); drain(1);
      cfg_barrier_clr_i = 1; barrier_i = 1; step(0, '0, 0);
      cur_req = "R10"; drain(2);
      cfg_alt_en_i = 1; alt_valid_i = 1; drain(1);
      step(1, 32'h7A0, 0); drain(2); cfg_alt_en_i = 0; alt_valid_i = 0;
      fill(1, 32'h7B0); barrier_i = 1; step(1, 32'h7C0, 0); drain(2);
      step(1, 32'h7D0, 0); drain(2);
      cur_req = "R8"; fill(2, 32'h800); vmexit_i = 1; step(0, '0, 0); drain(1);
      cfg_guard_i = 1; vmexit_i = 1; step(0, '0, 0); drain(2); cfg_guard_i = 0;
      cur_req = "R9"; cfg_barrier_clr_i = 0; fill(2, 32'h900); tlb_flush_i = 1;
      step(0, '0, 0); drain(1);
      cfg_tlb_clr_i = 1; tlb_flush_i = 1; step(0, '0, 0); drain(1);
      cur_req = "R12"; fill(3, 32'hC00); tlb_flush_i = 1; step(1, 32'hCF0, 1); drain(2);
      fill(2, 32'hD00); drain(3);
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule